// File: doc/BRIEF.md
# Immediate AND-Through-X Accumulator Datapath

This block models, cycle by cycle, how an 8-bit accumulator processor executes the unofficial immediate-mode instruction that merges the accumulator, the X index register and an operand byte. The internal buses are wired together, so the three values meet as a wired-AND. A per-chip constant lets selected accumulator bits pass the gate regardless of their value. The block captures the accumulator and X when the start strobe arrives, then samples the data bus once per clock.

While the ready line is low, the processor is stalled. Bus bytes seen during a stall, which are typically video or DMA traffic, are still latched and folded into the result. The operand byte on the first cycle with ready high ends the instruction. On some silicon a stall also forces one result bit low. A parameter selects that variant, and a second parameter selects which bit is affected.

The block writes the new accumulator, the negative flag and the zero flag once per instruction and raises a one-cycle done pulse at the same time. Between instructions these outputs hold their values.

Top module: `ane_exec`

## Requirements
- R1: After a synchronous active-low reset, acc_o is 0x00, neg_o is 0, zero_o is 1 and done_o is 0.
- R2: The cycle after an accepted start is the operand cycle. When ready is high there, the next cycle shows done_o = 1 and acc_o = (A OR MAGIC) AND X AND operand, with MAGIC = 0xEE by default.
- R3: A and X are taken only in the cycle where start is accepted. Changes to acc_i and xreg_i in later cycles do not alter the result.
- R4: Each cycle spent in the operand phase with rdy_i low ANDs that cycle's bus_i byte into the result, and the instruction continues.
- R5: With CLR_ON_STALL = 1, an instruction that saw at least one stall cycle commits with bit CLR_BIT (default 4) forced to 0. With CLR_ON_STALL = 0, that bit follows the AND.
- R6: At each commit, neg_o equals result bit 7 and zero_o is 1 exactly when the result is 0x00.
- R7: done_o is high for exactly one cycle per instruction, in the cycle after the first operand-phase cycle with rdy_i high. It stays low during stall cycles.
- R8: A start strobe that arrives while an instruction is in progress is ignored.
- R9: acc_o, neg_o and zero_o change only in a cycle where done_o is high. Bus, ready and register inputs have no effect on them between commits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Instruction start strobe |
| rdy_i | input | 1 | Ready line; low stalls the operand phase |
| acc_i | input | 8 | Current accumulator value |
| xreg_i | input | 8 | Current X index register value |
| bus_i | input | 8 | Data bus byte sampled each clock |
| acc_o | output | 8 | Committed accumulator |
| neg_o | output | 1 | Negative flag |
| zero_o | output | 1 | Zero flag |
| done_o | output | 1 | One-cycle commit pulse |

## Verification
The assertions check the following on every cycle:
- Ready high in the operand phase produces a done pulse on the next cycle.
- Two done pulses never occur back to back.
- The committed accumulator never has a bit set that was clear on the final operand byte.
- The flags agree with the result.
- The outputs stay stable outside commits.
- A stalled instruction clears the chosen bit when that option is on.
- A start during a stall does not end the instruction.

The exact merged value depends on the magic constant, on A and X captured at start, and on every stall byte. Only the bench's scenarios can show this, by comparing a formula-based expectation across an operand sweep, random stall sequences, and both bit-clear variants side by side.

// File: rtl/ane_pkg.sv
// Package: shared types for the accumulator AND-merge datapath.
// Assumes a two-state sequencer: idle, then one or more operand cycles.
package ane_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_OPER = 1'b1
    } ane_state_e;

endpackage

// File: rtl/ane_ctrl.sv
// Module: ane_ctrl
// Sequencer for one instruction. A start strobe seen while idle is accepted
// and moves to the operand phase. The phase stays there while the ready
// line is low, and the first ready-high cycle ends it with a commit.
// Assumes start_i and rdy_i are synchronous to clk.
module ane_ctrl
    import ane_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic rdy_i,
    output logic load_o,
    output logic busy_o,
    output logic commit_o
);

    ane_state_e state_q;
    ane_state_e state_d;

    // Decode the phase into strobes for the datapath.
    always_comb begin
        busy_o   = (state_q == ST_OPER);
        load_o   = start_i && (state_q == ST_IDLE);
        commit_o = busy_o && rdy_i;
    end

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_OPER;
            ST_OPER: if (rdy_i)   state_d = ST_IDLE;
            default:              state_d = ST_IDLE;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

endmodule

// File: rtl/ane_latch.sv
// Module: ane_latch
// Running wired-AND value. On load it seeds with (A | MAGIC) & X. Every
// operand-phase clock ANDs in the sampled bus byte, whether or not the cycle
// is stalled. It also records whether any stall happened, so that the
// optional bit clear can be applied to the result.
// Assumes load_i and busy_i are never high together.
module ane_latch #(
    parameter int unsigned       DW           = 8,
    parameter logic [DW-1:0]     MAGIC        = 8'hEE,
    parameter bit                CLR_ON_STALL = 1'b1,
    parameter int unsigned       CLR_BIT      = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          busy_i,
    input  logic          rdy_i,
    input  logic [DW-1:0] acc_i,
    input  logic [DW-1:0] xreg_i,
    input  logic [DW-1:0] bus_i,
    output logic [DW-1:0] result_o
);

    localparam logic [DW-1:0] ONE_HOT  = DW'(1) << CLR_BIT;
    localparam logic [DW-1:0] CLR_MASK = ~ONE_HOT;

    logic [DW-1:0] run_q;
    logic          stall_q;
    logic [DW-1:0] merged;
    logic [DW-1:0] mask;

    // Seed, accumulate and track stalls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= '0;
            stall_q <= 1'b0;
        end else if (load_i) begin
            run_q   <= (acc_i | MAGIC) & xreg_i;
            stall_q <= 1'b0;
        end else if (busy_i) begin
            run_q <= run_q & bus_i;
            if (!rdy_i) stall_q <= 1'b1;
        end
    end

    // Fold in the current bus byte, which is the real operand at commit.
    always_comb merged = run_q & bus_i;

    // Pick the stall variant selected by parameter.
    generate
        if (CLR_ON_STALL) begin : g_clr
            always_comb mask = stall_q ? CLR_MASK : '1;
        end else begin : g_keep
            always_comb mask = '1;
        end
    endgenerate

    // Final value presented to the commit stage.
    always_comb result_o = merged & mask;

endmodule

// File: rtl/ane_commit.sv
// Module: ane_commit
// Architectural write stage. On commit it stores the merged value as the
// new accumulator, derives negative and zero flags and pulses done.
// Otherwise every output holds.
// Assumes commit_i is high for at most one cycle per instruction.
module ane_commit #(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          commit_i,
    input  logic [DW-1:0] result_i,
    output logic [DW-1:0] acc_o,
    output logic          neg_o,
    output logic          zero_o,
    output logic          done_o
);

    // Register result, flags and the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_o  <= '0;
            neg_o  <= 1'b0;
            zero_o <= 1'b1;
            done_o <= 1'b0;
        end else begin
            done_o <= commit_i;
            if (commit_i) begin
                acc_o  <= result_i;
                neg_o  <= result_i[DW-1];
                zero_o <= (result_i == '0);
            end
        end
    end

endmodule

// File: rtl/ane_exec.sv
// Module: ane_exec (top)
// Cycle model of the immediate accumulator/X/operand wired-AND instruction,
// including ready-line stalls. A and X are captured with the start strobe.
// The bus is sampled on each following clock, and the result is written one
// cycle after the first ready-high operand cycle.
// Assumes all inputs are synchronous to clk.
module ane_exec #(
    parameter int unsigned   DW           = 8,
    parameter logic [DW-1:0] MAGIC        = 8'hEE,
    parameter bit            CLR_ON_STALL = 1'b1,
    parameter int unsigned   CLR_BIT      = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          rdy_i,
    input  logic [DW-1:0] acc_i,
    input  logic [DW-1:0] xreg_i,
    input  logic [DW-1:0] bus_i,
    output logic [DW-1:0] acc_o,
    output logic          neg_o,
    output logic          zero_o,
    output logic          done_o
);

    logic          load;
    logic          busy;
    logic          commit;
    logic [DW-1:0] result;

    ane_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .rdy_i    (rdy_i),
        .load_o   (load),
        .busy_o   (busy),
        .commit_o (commit)
    );

    ane_latch #(
        .DW           (DW),
        .MAGIC        (MAGIC),
        .CLR_ON_STALL (CLR_ON_STALL),
        .CLR_BIT      (CLR_BIT)
    ) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load),
        .busy_i   (busy),
        .rdy_i    (rdy_i),
        .acc_i    (acc_i),
        .xreg_i   (xreg_i),
        .bus_i    (bus_i),
        .result_o (result)
    );

    ane_commit #(
        .DW (DW)
    ) u_commit (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit_i (commit),
        .result_i (result),
        .acc_o    (acc_o),
        .neg_o    (neg_o),
        .zero_o   (zero_o),
        .done_o   (done_o)
    );

endmodule

// File: rtl/ane_exec_chk.sv
// Module: ane_exec_chk
// Property checker bound into ane_exec. It observes the ports and the
// sequencer busy flag. It keeps its own record of stalls per instruction.
module ane_exec_chk #(
    parameter int unsigned DW           = 8,
    parameter bit          CLR_ON_STALL = 1'b1,
    parameter int unsigned CLR_BIT      = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic          rdy_i,
    input logic [DW-1:0] bus_i,
    input logic          busy,
    input logic [DW-1:0] acc_o,
    input logic          neg_o,
    input logic          zero_o,
    input logic          done_o
);

    logic stalled_q;

    // Independent record of whether the current instruction stalled.
    always_ff @(posedge clk) begin
        if (!rst_n)                 stalled_q <= 1'b0;
        else if (start_i && !busy)  stalled_q <= 1'b0;
        else if (busy && !rdy_i)    stalled_q <= 1'b1;
    end

    // R2 / R7: ready high in the operand phase leads to a commit pulse.
    a_r2_ready_commits: assert property (@(posedge clk) disable iff (!rst_n)
        busy && rdy_i |=> done_o);

    // R7: done is a single-cycle pulse.
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R4: no result bit survives that was clear on the last operand byte.
    a_r4_operand_and: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ((acc_o & ~$past(bus_i)) == '0));

    // R6: flags agree with the committed result.
    a_r6_flags: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (neg_o == acc_o[DW-1]) && (zero_o == (acc_o == '0)));

    // R9: outputs hold between commits.
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(acc_o) && $stable(neg_o) && $stable(zero_o));

    // R8: a start during a stall neither ends nor restarts the instruction.
    a_r8_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start_i && !rdy_i |=> busy && !done_o);

    generate
        if (CLR_ON_STALL) begin : g_clr_chk
            // R5: a stalled instruction commits with the chosen bit low.
            a_r5_stall_clears: assert property (@(posedge clk) disable iff (!rst_n)
                done_o && stalled_q |-> !acc_o[CLR_BIT]);
        end
    endgenerate

endmodule

bind ane_exec ane_exec_chk #(
    .DW           (DW),
    .CLR_ON_STALL (CLR_ON_STALL),
    .CLR_BIT      (CLR_BIT)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .rdy_i   (rdy_i),
    .bus_i   (bus_i),
    .busy    (busy),
    .acc_o   (acc_o),
    .neg_o   (neg_o),
    .zero_o  (zero_o),
    .done_o  (done_o)
);

// File: tb/test_ane_exec.sv
`timescale 1ns/1ps
module test_ane_exec;

    localparam logic [7:0] TB_MAGIC = 8'hEE;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       rdy = 1'b1;
    logic [7:0] acc_in = '0;
    logic [7:0] x_in = '0;
    logic [7:0] bus = '0;

    logic [7:0] acc1, acc0;
    logic       neg1, neg0, zero1, zero0, done1, done0;

    logic [7:0] sb [0:7];

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    ane_exec #(.MAGIC(TB_MAGIC), .CLR_ON_STALL(1'b1)) i_ane_exec (
        .clk(clk), .rst_n(rst_n), .start_i(start), .rdy_i(rdy),
        .acc_i(acc_in), .xreg_i(x_in), .bus_i(bus),
        .acc_o(acc1), .neg_o(neg1), .zero_o(zero1), .done_o(done1));

    ane_exec #(.MAGIC(TB_MAGIC), .CLR_ON_STALL(1'b0)) i_ane_exec_nc (
        .clk(clk), .rst_n(rst_n), .start_i(start), .rdy_i(rdy),
        .acc_i(acc_in), .xreg_i(x_in), .bus_i(bus),
        .acc_o(acc0), .neg_o(neg0), .zero_o(zero0), .done_o(done0));

    task automatic chk(input string req, input logic ok,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Run one instruction from a negedge. Stall bytes come from sb[0:ns-1].
    task automatic run_op(input string req, input logic [7:0] a, input logic [7:0] x,
                          input logic [7:0] imm, input int ns, input bit poke);
        logic [7:0] e0;
        logic [7:0] e1;
        e0 = (a | TB_MAGIC) & x & imm;
        for (int i = 0; i < ns; i++) e0 = e0 & sb[i];
        e1 = e0;
        if (ns > 0) e1[4] = 1'b0;
        start = 1'b1; acc_in = a; x_in = x; rdy = 1'b1; bus = 8'h3C;
        @(negedge clk);
        start = 1'b0; acc_in = ~a; x_in = ~x;
        for (int i = 0; i < ns; i++) begin
            rdy = 1'b0; bus = sb[i]; start = poke;
            if (poke) begin acc_in = 8'hFF; x_in = 8'hFF; end
            @(negedge clk);
            chk({req, " R7 no done in stall"}, !done1 && !done0, {done1, done0}, 0);
        end
        start = 1'b0; rdy = 1'b1; bus = imm;
        @(negedge clk);
        chk({req, " clr-variant"}, {done1, acc1, neg1, zero1} == {1'b1, e1, e1[7], e1 == 8'h00},
            {done1, acc1, neg1, zero1}, {1'b1, e1, e1[7], e1 == 8'h00});
        chk({req, " keep-variant"}, {done0, acc0, neg0, zero0} == {1'b1, e0, e0[7], e0 == 8'h00},
            {done0, acc0, neg0, zero0}, {1'b1, e0, e0[7], e0 == 8'h00});
    endtask

    task automatic t_reset;
        chk("R1 reset", {acc1, neg1, zero1, done1} == {8'h00, 1'b0, 1'b1, 1'b0},
            {acc1, neg1, zero1, done1}, {8'h00, 1'b0, 1'b1, 1'b0});
        chk("R1 reset nc", {acc0, neg0, zero0, done0} == {8'h00, 1'b0, 1'b1, 1'b0},
            {acc0, neg0, zero0, done0}, {8'h00, 1'b0, 1'b1, 1'b0});
    endtask

    task automatic t_directed;
        run_op("R2 all ones", 8'hFF, 8'hFF, 8'hFF, 0, 1'b0);
        run_op("R2 R6 zero flag", 8'h00, 8'h11, 8'h11, 0, 1'b0);
        run_op("R2 R6 neg flag", 8'h00, 8'hFF, 8'hFF, 0, 1'b0);
        run_op("R3 inputs flip after start", 8'h5A, 8'hC3, 8'hF0, 0, 1'b0);
        sb[0] = 8'hFF;
        run_op("R5 bit4 one stall", 8'hFF, 8'hFF, 8'hFF, 1, 1'b0);
        sb[0] = 8'hF7; sb[1] = 8'h7F; sb[2] = 8'hFE;
        run_op("R4 three stall bytes", 8'hFF, 8'hFF, 8'hFF, 3, 1'b0);
    endtask

    task automatic t_sweep;
        for (int a = 0; a < 256; a += 17)
            for (int x = 0; x < 256; x += 17)
                for (int m = 0; m < 256; m += 5)
                    run_op("R2 sweep", 8'(a), 8'(x), 8'(m), 0, 1'b0);
    endtask

    task automatic t_stall_random;
        for (int n = 0; n < 300; n++) begin
            int ns;
            ns = 1 + int'($urandom_range(5));
            for (int i = 0; i < 8; i++) sb[i] = 8'($urandom) | 8'hD5;
            run_op("R4 R5 random stall", 8'($urandom), 8'($urandom) | 8'h10,
                   8'($urandom) | 8'h10, ns, 1'b0);
        end
    endtask

    task automatic t_busy_start;
        sb[0] = 8'hBF; sb[1] = 8'hFF;
        run_op("R8 start during stall", 8'h00, 8'h3C, 8'hFF, 2, 1'b1);
        @(negedge clk);
        chk("R7 R8 single done", !done1 && !done0, {done1, done0}, 0);
    endtask

    task automatic t_hold;
        logic [7:0] h1;
        logic [7:0] h0;
        run_op("R9 setup", 8'h9F, 8'hF3, 8'hBB, 0, 1'b0);
        h1 = acc1; h0 = acc0;
        for (int i = 0; i < 6; i++) begin
            rdy = 1'($urandom); bus = 8'($urandom);
            acc_in = 8'($urandom); x_in = 8'($urandom);
            @(negedge clk);
            chk("R9 hold", acc1 == h1 && acc0 == h0 && !done1 && !done0,
                {acc1, acc0, done1, done0}, {h1, h0, 2'b00});
        end
        rdy = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_directed();
        t_sweep();
        t_stall_random();
        t_busy_start();
        t_hold();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule